// File: doc/BRIEF.md
# Fully Associative Address-Space-Tagged Translation Buffer

This block is a small, fully associative translation buffer for a processor's memory unit. Each slot holds one page mapping: a virtual page tag, a physical page number, an 8-bit address-space identifier, a global bit, two 4-bit enable masks (read and write, one bit per privilege mode with kernel as mode 0), and a fault-on-read and a fault-on-write bit. A lookup presents a virtual page number and the current address-space identifier. One cycle later the block returns a registered hit flag, the winning slot index, and that slot's physical page and permission attributes. The permission decision itself is left to the caller.

The page-walk logic fills the buffer through an insert port. An insert always writes the slot named by a next-to-use pointer, which then advances round-robin. Maintenance operations are a full flush, a flush that spares global mappings, and a flush of every mapping that a given page and address space would hit. An indexed read returns the slot under the pointer and can optionally advance the pointer. This lets software walk the buffer or skip a slot.

Top module: `asn_tlb`

## Requirements
- R1: After reset no slot is valid, `nxt_ptr` is 0 and a lookup of any page, including page 0, misses.
- R2: A lookup with `lk_req` high hits when some slot is valid, its tag equals `lk_vpn`, and either its global bit is set or its stored identifier equals `lk_asn`. The cycle after the request, `lk_hit` is 1 and `lk_idx`, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_flt_rd` and `lk_flt_wr` carry that slot's contents. Without `lk_req`, `lk_hit` is 0 in the next cycle.
- R3: A non-global slot misses when the identifiers differ. A global slot hits under any identifier.
- R4: When several slots hit, the lowest index wins and is reported on `lk_idx`.
- R5: `ins_en` writes the slot at `nxt_ptr` with the given fields and marks it valid, replacing any valid mapping there. It then advances `nxt_ptr` by one.
- R6: The pointer wraps from DEPTH-1 to 0.
- R7: `fl_all` clears every slot and sets `nxt_ptr` to 0. It overrides an insert or a pointer advance in the same cycle.
- R8: `fl_user` invalidates every slot whose global bit is clear and leaves global slots valid.
- R9: `fl_addr` invalidates every slot that a lookup of `fl_vpn`/`fl_asn` would hit, and no other slot.
- R10: `rd_req` returns, one cycle later, the index and contents of the slot at `nxt_ptr` on `rd_idx`, `rd_vld`, `rd_tag`, `rd_ppn`, `rd_asn` and `rd_glob`. The pointer advances only when `rd_adv` is also high; otherwise it is unchanged unless an insert or flush moves it.
- R11: A lookup sees the contents from before the clock edge at which a same-cycle insert or flush takes effect. A slot written by an insert survives a selective flush issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_asn | input | ASN_W | Current address-space identifier |
| lk_hit | output | 1 | Registered hit flag |
| lk_idx | output | IDX_W | Winning slot index |
| lk_ppn | output | PPN_W | Physical page of winning slot |
| lk_rd_en | output | MODE_N | Read enable mask of winning slot |
| lk_wr_en | output | MODE_N | Write enable mask of winning slot |
| lk_flt_rd | output | 1 | Fault-on-read bit of winning slot |
| lk_flt_wr | output | 1 | Fault-on-write bit of winning slot |
| ins_en | input | 1 | Insert strobe |
| ins_vpn | input | VPN_W | Inserted tag |
| ins_ppn | input | PPN_W | Inserted physical page |
| ins_asn | input | ASN_W | Inserted identifier |
| ins_glob | input | 1 | Inserted global bit |
| ins_rd_en | input | MODE_N | Inserted read mask |
| ins_wr_en | input | MODE_N | Inserted write mask |
| ins_flt_rd | input | 1 | Inserted fault-on-read |
| ins_flt_wr | input | 1 | Inserted fault-on-write |
| fl_all | input | 1 | Flush every slot |
| fl_user | input | 1 | Flush non-global slots |
| fl_addr | input | 1 | Flush slots matching fl_vpn/fl_asn |
| fl_vpn | input | VPN_W | Page for address flush |
| fl_asn | input | ASN_W | Identifier for address flush |
| rd_req | input | 1 | Indexed read of slot at pointer |
| rd_adv | input | 1 | Advance pointer with the read |
| rd_idx | output | IDX_W | Index of the slot read |
| rd_vld | output | 1 | Valid bit of the slot read |
| rd_tag | output | VPN_W | Tag of the slot read |
| rd_ppn | output | PPN_W | Physical page of the slot read |
| rd_asn | output | ASN_W | Identifier of the slot read |
| rd_glob | output | 1 | Global bit of the slot read |
| nxt_ptr | output | IDX_W | Next-to-use pointer |

## Verification
Two kinds of collision are exercised. In the first, a lookup lands in the same cycle as an address flush or an insert of the same page; its result must reflect the contents before the edge, and a repeat lookup one cycle later must reflect the update. In the second, an insert meets a maintenance flush. With a full flush the insert is dropped and the pointer returns to 0. With a non-global flush the new non-global slot must survive. Each case is judged by follow-up lookups and by the pointer value.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;

    localparam int VPN_W  = 30;
    localparam int PPN_W  = 28;
    localparam int ASN_W  = 8;
    localparam int MODE_N = 4;

    typedef struct packed {
        logic              vld;
        logic [VPN_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [ASN_W-1:0]  asn;
        logic              glob;
        logic [MODE_N-1:0] rd_en;
        logic [MODE_N-1:0] wr_en;
        logic              flt_rd;
        logic              flt_wr;
    } tlb_ent_t;

    // Slot hit rule shared by lookup and address flush.
    function automatic logic ent_hits(input tlb_ent_t e,
                                      input logic [VPN_W-1:0] vpn,
                                      input logic [ASN_W-1:0] asn);
        return e.vld && (e.tag == vpn) && (e.glob || (e.asn == asn));
    endfunction

endpackage

// File: rtl/asn_tlb_match.sv
module asn_tlb_match
    import asn_tlb_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  tlb_ent_t           ents [DEPTH],
    input  logic [VPN_W-1:0]   vpn,
    input  logic [ASN_W-1:0]   asn,
    output logic [DEPTH-1:0]   hit_vec
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = ent_hits(ents[g], vpn, asn);
    end

endmodule

// File: rtl/asn_tlb_prio.sv
module asn_tlb_prio #(
    parameter int N     = 64,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     oh,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        oh  = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                oh[i] = 1'b1;
                idx   = IDX_W'(i);
                any   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/asn_tlb_store.sv
module asn_tlb_store
    import asn_tlb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fl_all,
    input  logic             fl_user,
    input  logic [DEPTH-1:0] fa_hit,
    input  logic             ins_en,
    input  tlb_ent_t         ins_ent,
    input  logic             step,
    output tlb_ent_t         ents [DEPTH],
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] ptr_nx;

    assign ptr_nx = (ptr == LAST) ? '0 : ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || fl_all) begin
            for (int i = 0; i < DEPTH; i++) begin
                ents[i] <= '0;
            end
            ptr <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((fl_user && !ents[i].glob) || fa_hit[i]) begin
                    ents[i].vld <= 1'b0;
                end
            end
            if (ins_en) begin
                ents[ptr]     <= ins_ent;
                ents[ptr].vld <= 1'b1;
            end
            if (ins_en || step) begin
                ptr <= ptr_nx;
            end
        end
    end

endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import asn_tlb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [MODE_N-1:0] lk_rd_en,
    output logic [MODE_N-1:0] lk_wr_en,
    output logic              lk_flt_rd,
    output logic              lk_flt_wr,
    input  logic              ins_en,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic              ins_glob,
    input  logic [MODE_N-1:0] ins_rd_en,
    input  logic [MODE_N-1:0] ins_wr_en,
    input  logic              ins_flt_rd,
    input  logic              ins_flt_wr,
    input  logic              fl_all,
    input  logic              fl_user,
    input  logic              fl_addr,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASN_W-1:0]  fl_asn,
    input  logic              rd_req,
    input  logic              rd_adv,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [VPN_W-1:0]  rd_tag,
    output logic [PPN_W-1:0]  rd_ppn,
    output logic [ASN_W-1:0]  rd_asn,
    output logic              rd_glob,
    output logic [IDX_W-1:0]  nxt_ptr
);

    tlb_ent_t         ents [DEPTH];
    tlb_ent_t         ins_ent;
    tlb_ent_t         win_ent;
    tlb_ent_t         ptr_ent;
    logic [DEPTH-1:0] lk_vec;
    logic [DEPTH-1:0] fa_vec;
    logic [DEPTH-1:0] fa_hit;
    logic [DEPTH-1:0] win_oh;
    logic [IDX_W-1:0] win_idx;
    logic             win_any;
    logic             step;

    always_comb begin
        ins_ent        = '0;
        ins_ent.tag    = ins_vpn;
        ins_ent.ppn    = ins_ppn;
        ins_ent.asn    = ins_asn;
        ins_ent.glob   = ins_glob;
        ins_ent.rd_en  = ins_rd_en;
        ins_ent.wr_en  = ins_wr_en;
        ins_ent.flt_rd = ins_flt_rd;
        ins_ent.flt_wr = ins_flt_wr;
    end

    assign fa_hit = fl_addr ? fa_vec : '0;
    assign step   = rd_req & rd_adv;

    asn_tlb_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .fl_all  (fl_all),
        .fl_user (fl_user),
        .fa_hit  (fa_hit),
        .ins_en  (ins_en),
        .ins_ent (ins_ent),
        .step    (step),
        .ents    (ents),
        .ptr     (nxt_ptr)
    );

    asn_tlb_match #(.DEPTH(DEPTH)) u_lk_match (
        .ents    (ents),
        .vpn     (lk_vpn),
        .asn     (lk_asn),
        .hit_vec (lk_vec)
    );

    asn_tlb_match #(.DEPTH(DEPTH)) u_fa_match (
        .ents    (ents),
        .vpn     (fl_vpn),
        .asn     (fl_asn),
        .hit_vec (fa_vec)
    );

    asn_tlb_prio #(.N(DEPTH), .IDX_W(IDX_W)) u_prio (
        .req (lk_vec),
        .oh  (win_oh),
        .idx (win_idx),
        .any (win_any)
    );

    assign win_ent = ents[win_idx];
    assign ptr_ent = ents[nxt_ptr];

    // Registered lookup result
    always_ff @(posedge clk) begin
        if (rst || !(lk_req && win_any)) begin
            lk_hit    <= 1'b0;
            lk_idx    <= '0;
            lk_ppn    <= '0;
            lk_rd_en  <= '0;
            lk_wr_en  <= '0;
            lk_flt_rd <= 1'b0;
            lk_flt_wr <= 1'b0;
        end else begin
            lk_hit    <= 1'b1;
            lk_idx    <= win_idx;
            lk_ppn    <= win_ent.ppn;
            lk_rd_en  <= win_ent.rd_en;
            lk_wr_en  <= win_ent.wr_en;
            lk_flt_rd <= win_ent.flt_rd;
            lk_flt_wr <= win_ent.flt_wr;
        end
    end

    // Registered indexed read of the slot under the pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx  <= '0;
            rd_vld  <= 1'b0;
            rd_tag  <= '0;
            rd_ppn  <= '0;
            rd_asn  <= '0;
            rd_glob <= 1'b0;
        end else if (rd_req) begin
            rd_idx  <= nxt_ptr;
            rd_vld  <= ptr_ent.vld;
            rd_tag  <= ptr_ent.tag;
            rd_ppn  <= ptr_ent.ppn;
            rd_asn  <= ptr_ent.asn;
            rd_glob <= ptr_ent.glob;
        end
    end

endmodule

// File: rtl/asn_tlb_chk.sv
module asn_tlb_chk #(
    parameter int DEPTH = 64,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_req,
    input logic             lk_hit,
    input logic             ins_en,
    input logic             fl_all,
    input logic             rd_req,
    input logic             rd_adv,
    input logic [IDX_W-1:0] rd_idx,
    input logic [IDX_W-1:0] nxt_ptr,
    input logic [DEPTH-1:0] win_oh
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    // R2
    no_req_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !lk_hit);

    // R4
    single_winner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_oh));

    // R5
    ins_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !fl_all) |=>
            (nxt_ptr == (($past(nxt_ptr) == LAST) ? '0 : $past(nxt_ptr) + 1'b1)));

    // R7
    flush_ptr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        fl_all |=> (nxt_ptr == '0));

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fl_all && !ins_en && !(rd_req && rd_adv)) |=> $stable(nxt_ptr));

    // R10
    rd_index_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> (rd_idx == $past(nxt_ptr)));

endmodule

bind asn_tlb asn_tlb_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .lk_req  (lk_req),
    .lk_hit  (lk_hit),
    .ins_en  (ins_en),
    .fl_all  (fl_all),
    .rd_req  (rd_req),
    .rd_adv  (rd_adv),
    .rd_idx  (rd_idx),
    .nxt_ptr (nxt_ptr),
    .win_oh  (win_oh)
);

// File: tb/sim_asn_tlb.sv
`timescale 1ns/1ps
module sim_asn_tlb;
    import asn_tlb_pkg::*;

    localparam int D  = 8;
    localparam int IW = $clog2(D);

    logic clk = 1'b0;
    logic rst;
    always #4 clk = ~clk;

    logic              lk_req;
    logic [VPN_W-1:0]  lk_vpn;
    logic [ASN_W-1:0]  lk_asn;
    logic              lk_hit;
    logic [IW-1:0]     lk_idx;
    logic [PPN_W-1:0]  lk_ppn;
    logic [MODE_N-1:0] lk_rd_en, lk_wr_en;
    logic              lk_flt_rd, lk_flt_wr;
    logic              ins_en;
    logic [VPN_W-1:0]  ins_vpn;
    logic [PPN_W-1:0]  ins_ppn;
    logic [ASN_W-1:0]  ins_asn;
    logic              ins_glob;
    logic [MODE_N-1:0] ins_rd_en, ins_wr_en;
    logic              ins_flt_rd, ins_flt_wr;
    logic              fl_all, fl_user, fl_addr;
    logic [VPN_W-1:0]  fl_vpn;
    logic [ASN_W-1:0]  fl_asn;
    logic              rd_req, rd_adv;
    logic [IW-1:0]     rd_idx;
    logic              rd_vld;
    logic [VPN_W-1:0]  rd_tag;
    logic [PPN_W-1:0]  rd_ppn;
    logic [ASN_W-1:0]  rd_asn;
    logic              rd_glob;
    logic [IW-1:0]     nxt_ptr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    asn_tlb #(.DEPTH(D)) u0 (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        lk_req = 0; lk_vpn = '0; lk_asn = '0;
        ins_en = 0; ins_vpn = '0; ins_ppn = '0; ins_asn = '0; ins_glob = 0;
        ins_rd_en = '0; ins_wr_en = '0; ins_flt_rd = 0; ins_flt_wr = 0;
        fl_all = 0; fl_user = 0; fl_addr = 0; fl_vpn = '0; fl_asn = '0;
        rd_req = 0; rd_adv = 0;
    endtask

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic set_ins(input int vpn, input int ppn, input int asn, input bit g);
        ins_en = 1; ins_vpn = VPN_W'(vpn); ins_ppn = PPN_W'(ppn);
        ins_asn = ASN_W'(asn); ins_glob = g;
        ins_rd_en = 4'b0011; ins_wr_en = 4'b0001; ins_flt_rd = 0; ins_flt_wr = 0;
    endtask

    task automatic insert(input int vpn, input int ppn, input int asn, input bit g);
        set_ins(vpn, ppn, asn, g);
        tick();
        idle();
    endtask

    task automatic lookup(input int vpn, input int asn);
        lk_req = 1; lk_vpn = VPN_W'(vpn); lk_asn = ASN_W'(asn);
        tick();
        idle();
    endtask

    task automatic t_reset();
        rst = 1; idle();
        repeat (3) tick();
        rst = 0;
        chk("R1 hit after reset", 64'(lk_hit), 0);
        chk("R1 ptr after reset", 64'(nxt_ptr), 0);
        lookup(0, 0);
        chk("R1 page 0 misses", 64'(lk_hit), 0);
    endtask

    task automatic t_basic();
        set_ins(32'h100, 32'hA, 5, 0);
        ins_rd_en = 4'b0011; ins_wr_en = 4'b0001; ins_flt_wr = 1;
        tick(); idle();
        chk("R5 ptr after insert", 64'(nxt_ptr), 1);
        lookup(32'h100, 5);
        chk("R2 hit", 64'(lk_hit), 1);
        chk("R2 idx", 64'(lk_idx), 0);
        chk("R2 ppn", 64'(lk_ppn), 64'hA);
        chk("R2 rd mask", 64'(lk_rd_en), 3);
        chk("R2 wr mask", 64'(lk_wr_en), 1);
        chk("R2 fault bits", 64'({lk_flt_rd, lk_flt_wr}), 1);
    endtask

    task automatic t_asn_global();
        lookup(32'h100, 6);
        chk("R3 asn mismatch misses", 64'(lk_hit), 0);
        insert(32'h200, 32'hB, 1, 1);
        lookup(32'h200, 32'h77);
        chk("R3 global hit", 64'(lk_hit), 1);
        chk("R3 global idx", 64'(lk_idx), 1);
        chk("R3 global ppn", 64'(lk_ppn), 64'hB);
    endtask

    task automatic t_priority();
        insert(32'h300, 32'hC, 2, 0);
        insert(32'h300, 32'hD, 32'h40, 1);
        lookup(32'h300, 2);
        chk("R4 lowest idx", 64'(lk_idx), 2);
        chk("R4 lowest ppn", 64'(lk_ppn), 64'hC);
        lookup(32'h300, 9);
        chk("R4 global only idx", 64'(lk_idx), 3);
    endtask

    task automatic t_flush_addr();
        fl_addr = 1; fl_vpn = VPN_W'(32'h300); fl_asn = 2;
        tick(); idle();
        lookup(32'h300, 2);
        chk("R9 asn entry gone", 64'(lk_hit), 0);
        lookup(32'h300, 9);
        chk("R9 global entry gone", 64'(lk_hit), 0);
        fl_addr = 1; fl_vpn = VPN_W'(32'h100); fl_asn = 6;
        tick(); idle();
        lookup(32'h100, 5);
        chk("R9 unmatched survives", 64'(lk_hit), 1);
    endtask

    task automatic t_flush_user();
        fl_user = 1;
        tick(); idle();
        lookup(32'h100, 5);
        chk("R8 non-global gone", 64'(lk_hit), 0);
        lookup(32'h200, 3);
        chk("R8 global kept", 64'(lk_hit), 1);
        chk("R8 ptr unchanged", 64'(nxt_ptr), 4);
    endtask

    task automatic t_read_wrap();
        rd_req = 1;
        tick(); idle();
        chk("R10 rd idx", 64'(rd_idx), 4);
        chk("R10 rd empty slot", 64'(rd_vld), 0);
        chk("R10 no advance", 64'(nxt_ptr), 4);
        for (int i = 0; i < 4; i++) insert(32'h400 + i, 32'h40 + i, 3, 0);
        chk("R6 wrap to 0", 64'(nxt_ptr), 0);
        insert(32'h500, 32'h50, 3, 0);
        lookup(32'h500, 3);
        chk("R6 slot 0 reused", 64'(lk_idx), 0);
        rd_req = 1;
        tick(); idle();
        chk("R10 rd vld", 64'(rd_vld), 1);
        chk("R10 rd tag", 64'(rd_tag), 64'h200);
        chk("R10 rd ppn/asn/glob", 64'({rd_ppn, rd_asn, rd_glob}), 64'({PPN_W'(32'hB), ASN_W'(1), 1'b1}));
        chk("R10 hold ptr", 64'(nxt_ptr), 1);
        rd_req = 1; rd_adv = 1;
        tick(); idle();
        chk("R10 adv rd idx", 64'(rd_idx), 1);
        chk("R10 advanced", 64'(nxt_ptr), 2);
    endtask

    task automatic t_overwrite();
        for (int i = 0; i < 2; i++) begin
            rd_req = 1; rd_adv = 1;
            tick(); idle();
        end
        chk("R10 two advances", 64'(nxt_ptr), 4);
        insert(32'h600, 32'h60, 3, 0);
        lookup(32'h400, 3);
        chk("R5 old mapping replaced", 64'(lk_hit), 0);
        lookup(32'h600, 3);
        chk("R5 new mapping idx", 64'(lk_idx), 4);
    endtask

    task automatic t_same_cycle();
        lk_req = 1; lk_vpn = VPN_W'(32'h600); lk_asn = 3;
        fl_addr = 1; fl_vpn = VPN_W'(32'h600); fl_asn = 3;
        tick(); idle();
        chk("R11 lookup sees pre-flush", 64'(lk_hit), 1);
        lookup(32'h600, 3);
        chk("R9 flushed after edge", 64'(lk_hit), 0);
        set_ins(32'h700, 32'h70, 4, 0);
        lk_req = 1; lk_vpn = VPN_W'(32'h700); lk_asn = 4;
        tick(); idle();
        chk("R11 lookup sees pre-insert", 64'(lk_hit), 0);
        lookup(32'h700, 4);
        chk("R11 insert visible next", 64'(lk_idx), 5);
        set_ins(32'h710, 32'h71, 4, 0);
        fl_all = 1;
        tick(); idle();
        chk("R7 ptr zero over insert", 64'(nxt_ptr), 0);
        lookup(32'h710, 4);
        chk("R7 insert dropped", 64'(lk_hit), 0);
        lookup(32'h401, 3);
        chk("R7 all cleared", 64'(lk_hit), 0);
        set_ins(32'h720, 32'h72, 4, 0);
        fl_user = 1;
        tick(); idle();
        lookup(32'h720, 4);
        chk("R11 insert survives user flush", 64'(lk_hit), 1);
        chk("R11 ptr after", 64'(nxt_ptr), 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_asn_global();
        t_priority();
        t_flush_addr();
        t_flush_user();
        t_read_wrap();
        t_overwrite();
        t_same_cycle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule